// File: doc/BRIEF.md
# Codec sample-rate pacing controller

This block paces two codec sample streams, audio and telecom, from one serial-port bit clock. The bit clock reaches the block as a one-cycle enable tick. Each stream has its own rate counter. The counter divides the tick rate by 32 times a programmable divisor and emits a one-cycle transmit request strobe each time it expires. The strobe tells the transmit path that the next converter sample must be fetched from that stream's transmit FIFO.

On the receive side the block decides, cycle by cycle, when a sample that the frame logic has flagged as valid is written into the stream's receive FIFO. It has two capture policies:
- Follow mode writes on every valid flag.
- Paced mode writes the first valid sample, then writes only on that stream's counter expiries.

A single control word holds the divisors, the port enable, the capture policy and the telecom interrupt mask. The block also forwards the telecom transmit-FIFO low-level status as an interrupt.

The block carries no data of its own. The store and request outputs are plain single-cycle strobes, and the receive valid inputs are level flags sampled every cycle. There is therefore no valid/ready handshake and no back-pressure: a FIFO that is full must drop or flag overflow on its own side.

Top module: `sample_pacer`

## Requirements
- R1: After reset the control word reads 0x0000_1006 (audio divisor 6, telecom divisor 16, all flags 0). Every strobe, store and interrupt output is 0, and `port_en` is 0.
- R2: The control word uses these bit positions:
  - bits 6..0: audio divisor
  - bits 14..8: telecom divisor
  - bit 16: port enable
  - bit 18: paced capture
  - bit 19: telecom interrupt mask

  All other bits read as 0 whatever was written, so writing all ones reads back 0x000D_7F7F.
- R3: A divisor write below the minimum is stored as the minimum: 6 for audio and 16 for telecom. Values at or above the minimum are stored unchanged.
- R4: While enabled with divisor D and a tick on every cycle, consecutive transmit strobes of a stream are exactly 32×D cycles apart. Each strobe lasts one cycle and follows a cycle that carried a tick.
- R5: Setting the port enable bit restarts the counters. The first cycle with the bit set loads the counter and ignores its tick. The first strobe then appears one cycle after the 32×D-th following tick, which is 32×D+1 cycles after the write edge when ticks are continuous.
- R6: A divisor written while a stream is counting takes effect only at that stream's next reload. The interval in progress keeps the old length and the next one uses the new length.
- R7: With paced capture 0 and the port enabled, each stream's store output equals its receive valid input in the same cycle.
- R8: With paced capture 1, a stream's first valid flag produces a store in the same cycle and arms the stream. From the next cycle on, the stream stores exactly on its transmit strobe cycles, whatever the valid input is.
- R9: Clearing the port enable disarms both streams, so after re-enable the first valid flag again stores at once.
- R10: `tel_tx_irq` is 1 exactly when the port is enabled, the telecom interrupt mask bit is 1 and `tel_tx_low` is 1.
- R11: While the port enable is 0, `port_en` is 0 and no strobe, store or interrupt is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Current control word |
| bit_tick | input | 1 | One-cycle pulse per serial bit clock period |
| aud_rx_valid | input | 1 | Audio receive sample valid flag |
| tel_rx_valid | input | 1 | Telecom receive sample valid flag |
| tel_tx_low | input | 1 | Telecom transmit FIFO at half-full or below |
| aud_tx_req | output | 1 | Audio transmit sample request strobe |
| tel_tx_req | output | 1 | Telecom transmit sample request strobe |
| aud_rx_store | output | 1 | Write audio receive sample into its FIFO |
| tel_rx_store | output | 1 | Write telecom receive sample into its FIFO |
| tel_tx_irq | output | 1 | Masked telecom transmit low-level interrupt |
| port_en | output | 1 | Port owns its serial pins |

## Verification
The bench builds the block with its default parameters:

| Parameter | Value |
|---|---|
| Divisor width | 7 bits |
| Prescale | 32 |
| Audio minimum | 6 |
| Telecom minimum | 16 |

It holds the tick high on every cycle during period checks. Even the largest divisor then gives a 4064-cycle interval, so the smallest and largest divisors of both streams are measured directly, along with random divisors. Because the 12-bit counter reaches its full reload value of 4063 at the largest divisor, the top end of the count range is exercised as well as the clamping floor.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int N_STREAMS = 2;
  localparam int S_AUD     = 0;
  localparam int S_TEL     = 1;

  // control word bit positions
  localparam int AUD_LSB = 0;
  localparam int TEL_LSB = 8;
  localparam int EN_BIT  = 16;
  localparam int PACE_BIT = 18;
  localparam int MASK_BIT = 19;

  typedef struct packed {
    logic irq_mask;
    logic paced;
    logic enable;
  } sp_mode_t;
endpackage

// File: rtl/sp_ctrl_reg.sv
module sp_ctrl_reg
  import sp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 7,
  parameter int AUD_MIN = 6,
  parameter int TEL_MIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DIV_W-1:0]  aud_div,
  output logic [DIV_W-1:0]  tel_div,
  output sp_mode_t          mode,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DIV_W-1:0] AUD_FLOOR = DIV_W'(AUD_MIN);
  localparam logic [DIV_W-1:0] TEL_FLOOR = DIV_W'(TEL_MIN);

  function automatic logic [DIV_W-1:0] floor_div(input logic [DIV_W-1:0] v,
                                                 input logic [DIV_W-1:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aud_div <= AUD_FLOOR;
      tel_div <= TEL_FLOOR;
      mode    <= '0;
    end else if (wr_en) begin
      aud_div       <= floor_div(wdata[AUD_LSB +: DIV_W], AUD_FLOOR);
      tel_div       <= floor_div(wdata[TEL_LSB +: DIV_W], TEL_FLOOR);
      mode.enable   <= wdata[EN_BIT];
      mode.paced    <= wdata[PACE_BIT];
      mode.irq_mask <= wdata[MASK_BIT];
    end
  end

  always_comb begin
    rdata                    = '0;
    rdata[AUD_LSB +: DIV_W]  = aud_div;
    rdata[TEL_LSB +: DIV_W]  = tel_div;
    rdata[EN_BIT]            = mode.enable;
    rdata[PACE_BIT]          = mode.paced;
    rdata[MASK_BIT]          = mode.irq_mask;
  end
endmodule

// File: rtl/sp_stream.sv
module sp_stream #(
  parameter int DIV_W    = 7,
  parameter int PRESCALE = 32,
  parameter int CNT_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             paced,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  input  logic             rx_valid,
  output logic             tx_req,
  output logic             rx_store
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;
  logic             primed;
  logic             expire;
  logic             armed;

  assign reload = CNT_W'(PRESCALE) * CNT_W'(div) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      primed <= 1'b0;
      expire <= 1'b0;
      armed  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (!en) begin
        primed <= 1'b0;
        cnt    <= '0;
      end else if (!primed) begin
        primed <= 1'b1;
        cnt    <= reload;
      end else if (tick) begin
        if (cnt == '0) begin
          cnt    <= reload;
          expire <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
      armed <= en & paced & (armed | rx_valid);
    end
  end

  assign tx_req   = en & expire;
  assign rx_store = en & ((paced & armed) ? expire : rx_valid);
endmodule

// File: rtl/sample_pacer.sv
module sample_pacer
  import sp_pkg::*;
#(
  parameter int DIV_W    = 7,
  parameter int PRESCALE = 32,
  parameter int AUD_MIN  = 6,
  parameter int TEL_MIN  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        bit_tick,
  input  logic        aud_rx_valid,
  input  logic        tel_rx_valid,
  input  logic        tel_tx_low,
  output logic        aud_tx_req,
  output logic        tel_tx_req,
  output logic        aud_rx_store,
  output logic        tel_rx_store,
  output logic        tel_tx_irq,
  output logic        port_en
);
  localparam int CNT_W = $clog2(PRESCALE * (2 ** DIV_W));

  logic [DIV_W-1:0]     div_a [N_STREAMS];
  logic [N_STREAMS-1:0] valid_v;
  logic [N_STREAMS-1:0] req_v;
  logic [N_STREAMS-1:0] store_v;
  sp_mode_t             mode;

  sp_ctrl_reg #(
    .DATA_W (32),
    .DIV_W  (DIV_W),
    .AUD_MIN(AUD_MIN),
    .TEL_MIN(TEL_MIN)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .wdata  (reg_wdata),
    .aud_div(div_a[S_AUD]),
    .tel_div(div_a[S_TEL]),
    .mode   (mode),
    .rdata  (reg_rdata)
  );

  assign valid_v[S_AUD] = aud_rx_valid;
  assign valid_v[S_TEL] = tel_rx_valid;

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
    sp_stream #(
      .DIV_W   (DIV_W),
      .PRESCALE(PRESCALE),
      .CNT_W   (CNT_W)
    ) u_stream (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (mode.enable),
      .paced   (mode.paced),
      .tick    (bit_tick),
      .div     (div_a[s]),
      .rx_valid(valid_v[s]),
      .tx_req  (req_v[s]),
      .rx_store(store_v[s])
    );
  end

  assign aud_tx_req   = req_v[S_AUD];
  assign tel_tx_req   = req_v[S_TEL];
  assign aud_rx_store = store_v[S_AUD];
  assign tel_rx_store = store_v[S_TEL];
  assign tel_tx_irq   = mode.enable & mode.irq_mask & tel_tx_low;
  assign port_en      = mode.enable;
endmodule

// File: rtl/sp_pacer_chk.sv
module sp_pacer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rdata,
  input logic        bit_tick,
  input logic        aud_rx_valid,
  input logic        tel_rx_valid,
  input logic        tel_tx_low,
  input logic        aud_tx_req,
  input logic        tel_tx_req,
  input logic        aud_rx_store,
  input logic        tel_rx_store,
  input logic        tel_tx_irq,
  input logic        port_en
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~32'h000D_7F7F) == 32'h0);

  // R3
  div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[6:0] >= 7'd6) && (reg_rdata[14:8] >= 7'd16));

  // R4
  aud_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aud_tx_req |=> !aud_tx_req);

  // R4
  tel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tel_tx_req |=> !tel_tx_req);

  // R4
  aud_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aud_tx_req |-> $past(bit_tick));

  // R7
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !reg_rdata[18]) |->
      (aud_rx_store == aud_rx_valid) && (tel_rx_store == tel_rx_valid));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tel_tx_irq == (port_en && reg_rdata[19] && tel_tx_low));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !(aud_tx_req || tel_tx_req || aud_rx_store ||
                   tel_rx_store || tel_tx_irq));
endmodule

bind sample_pacer sp_pacer_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rdata   (reg_rdata),
  .bit_tick    (bit_tick),
  .aud_rx_valid(aud_rx_valid),
  .tel_rx_valid(tel_rx_valid),
  .tel_tx_low  (tel_tx_low),
  .aud_tx_req  (aud_tx_req),
  .tel_tx_req  (tel_tx_req),
  .aud_rx_store(aud_rx_store),
  .tel_rx_store(tel_rx_store),
  .tel_tx_irq  (tel_tx_irq),
  .port_en     (port_en)
);

// File: tb/test_sample_pacer.sv
`timescale 1ns/1ps
module test_sample_pacer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bit_tick = 1'b0;
  logic        aud_rx_valid = 1'b0;
  logic        tel_rx_valid = 1'b0;
  logic        tel_tx_low = 1'b0;
  logic        aud_tx_req, tel_tx_req, aud_rx_store, tel_rx_store;
  logic        tel_tx_irq, port_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sample_pacer i_sample_pacer (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bit_tick(bit_tick), .aud_rx_valid(aud_rx_valid),
    .tel_rx_valid(tel_rx_valid), .tel_tx_low(tel_tx_low),
    .aud_tx_req(aud_tx_req), .tel_tx_req(tel_tx_req),
    .aud_rx_store(aud_rx_store), .tel_rx_store(tel_rx_store),
    .tel_tx_irq(tel_tx_irq), .port_en(port_en)
  );

  function automatic int floor_div(int v, int lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic logic [31:0] word(int a, int t, bit en, bit paced, bit mask);
    logic [31:0] w;
    w = '0;
    w[6:0]  = 7'(a);
    w[14:8] = 7'(t);
    w[16]   = en;
    w[18]   = paced;
    w[19]   = mask;
    return w;
  endfunction

  function automatic logic [31:0] expect_word(int a, int t, bit en, bit paced, bit mask);
    return word(floor_div(a, 6), floor_div(t, 16), en, paced, mask);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_strobe(int sel, output int n);
    n = 0;
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if ((sel == 0) ? aud_tx_req : tel_tx_req) break;
    end
  endtask

  initial begin
    #760000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, a, t, ok;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(reg_rdata == 32'h0000_1006, "R1 rdata", reg_rdata, 32'h1006);
    check({aud_tx_req, tel_tx_req, aud_rx_store, tel_rx_store, tel_tx_irq, port_en} == 6'b0,
          "R1 outputs", {aud_tx_req, tel_tx_req, aud_rx_store, tel_rx_store, tel_tx_irq, port_en}, 0);

    // R2 layout and reserved bits
    reg_write(32'hFFFF_FFFF);
    check(reg_rdata == 32'h000D_7F7F, "R2 all ones", reg_rdata, 32'h000D_7F7F);
    reg_write(32'h0);

    // R3 clamping, directed boundaries and random values
    reg_write(word(2, 5, 0, 0, 0));
    check(reg_rdata == expect_word(2, 5, 0, 0, 0), "R3 low", reg_rdata, expect_word(2, 5, 0, 0, 0));
    reg_write(word(5, 15, 0, 0, 0));
    check(reg_rdata == expect_word(5, 15, 0, 0, 0), "R3 min-1", reg_rdata, expect_word(5, 15, 0, 0, 0));
    reg_write(word(6, 16, 0, 0, 0));
    check(reg_rdata == expect_word(6, 16, 0, 0, 0), "R3 min", reg_rdata, expect_word(6, 16, 0, 0, 0));
    for (int k = 0; k < 6; k++) begin
      a = $urandom % 128;
      t = $urandom % 128;
      reg_write(word(a, t, 0, 0, 0));
      check(reg_rdata == expect_word(a, t, 0, 0, 0), "R3 random", reg_rdata, expect_word(a, t, 0, 0, 0));
    end

    // R11 disabled: nothing moves
    reg_write(word(6, 16, 0, 0, 1));
    bit_tick = 1'b1; aud_rx_valid = 1'b1; tel_rx_valid = 1'b1; tel_tx_low = 1'b1;
    ok = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (aud_tx_req | tel_tx_req | aud_rx_store | tel_rx_store | tel_tx_irq | port_en) ok++;
    end
    check(ok == 0, "R11 quiet", ok, 0);
    aud_rx_valid = 1'b0; tel_rx_valid = 1'b0; tel_tx_low = 1'b0;

    // R4 / R5 periods, directed extremes then random
    for (int k = 0; k < 3; k++) begin
      a = (k == 0) ? 6 : (k == 1) ? 127 : 6 + ($urandom % 122);
      t = (k == 0) ? 127 : (k == 1) ? 16 : 16 + ($urandom % 112);
      reg_write(word(a, t, 0, 0, 0));
      reg_write(word(a, t, 1, 0, 0));
      wait_strobe(0, n);
      check(n == 32 * a + 1, "R5 audio first", n, 32 * a + 1);
      wait_strobe(0, n);
      check(n == 32 * a, "R4 audio period", n, 32 * a);
      reg_write(word(a, t, 0, 0, 0));
      reg_write(word(a, t, 1, 0, 0));
      wait_strobe(1, n);
      check(n == 32 * t + 1, "R5 telecom first", n, 32 * t + 1);
      wait_strobe(1, n);
      check(n == 32 * t, "R4 telecom period", n, 32 * t);
    end

    // R5 restart after mid-count disable
    reg_write(word(8, 16, 1, 0, 0));
    repeat (100) @(negedge clk);
    reg_write(word(8, 16, 0, 0, 0));
    reg_write(word(8, 16, 1, 0, 0));
    wait_strobe(0, n);
    check(n == 32 * 8 + 1, "R5 restart", n, 32 * 8 + 1);

    // R6 divisor change deferred to reload
    reg_write(word(10, 16, 0, 0, 0));
    reg_write(word(10, 16, 1, 0, 0));
    wait_strobe(0, n);
    reg_write(word(20, 16, 1, 0, 0));
    wait_strobe(0, n);
    // the write task consumes two cycles of the running interval
    check(n == 32 * 10 - 2, "R6 old length", n, 32 * 10 - 2);
    wait_strobe(0, n);
    check(n == 32 * 20, "R6 new length", n, 32 * 20);

    // R10 interrupt masking
    tel_tx_low = 1'b1;
    reg_write(word(6, 16, 1, 0, 0));
    check(tel_tx_irq == 1'b0, "R10 masked", tel_tx_irq, 0);
    reg_write(word(6, 16, 1, 0, 1));
    check(tel_tx_irq == 1'b1, "R10 unmasked", tel_tx_irq, 1);
    tel_tx_low = 1'b0;
    #1;
    check(tel_tx_irq == 1'b0, "R10 status low", tel_tx_irq, 0);
    tel_tx_low = 1'b1;
    reg_write(word(6, 16, 0, 0, 1));
    check(tel_tx_irq == 1'b0, "R11 irq disabled", tel_tx_irq, 0);
    tel_tx_low = 1'b0;

    // R7 follow mode, random valid patterns
    reg_write(word(6, 16, 1, 0, 0));
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      aud_rx_valid = 1'($urandom);
      tel_rx_valid = 1'($urandom);
      #1;
      check(aud_rx_store == aud_rx_valid, "R7 audio", aud_rx_store, aud_rx_valid);
      check(tel_rx_store == tel_rx_valid, "R7 telecom", tel_rx_store, tel_rx_valid);
    end
    aud_rx_valid = 1'b0; tel_rx_valid = 1'b0;

    // R8 paced capture
    bit_tick = 1'b0;
    reg_write(word(6, 16, 0, 0, 0));
    reg_write(word(6, 16, 1, 1, 0));
    @(negedge clk);
    aud_rx_valid = 1'b1; tel_rx_valid = 1'b1;
    #1;
    check(aud_rx_store == 1'b1, "R8 first audio", aud_rx_store, 1);
    check(tel_rx_store == 1'b1, "R8 first telecom", tel_rx_store, 1);
    @(negedge clk);
    check(aud_rx_store == 1'b0, "R8 armed audio ignores valid", aud_rx_store, 0);
    check(tel_rx_store == 1'b0, "R8 armed telecom ignores valid", tel_rx_store, 0);
    aud_rx_valid = 1'b0; tel_rx_valid = 1'b0;
    bit_tick = 1'b1;
    wait_strobe(0, n);
    check(aud_rx_store == 1'b1, "R8 store on strobe", aud_rx_store, 1);
    @(negedge clk);
    check(aud_rx_store == 1'b0, "R8 store after strobe", aud_rx_store, 0);

    // R9 re-arm after disable
    bit_tick = 1'b0;
    reg_write(word(6, 16, 0, 1, 0));
    aud_rx_valid = 1'b1;
    #1;
    check(aud_rx_store == 1'b0, "R11 store disabled", aud_rx_store, 0);
    aud_rx_valid = 1'b0;
    reg_write(word(6, 16, 1, 1, 0));
    aud_rx_valid = 1'b1;
    #1;
    check(aud_rx_store == 1'b1, "R9 rearm", aud_rx_store, 1);
    @(negedge clk);
    aud_rx_valid = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule